// File: doc/BRIEF.md
# Banked Register File with Indirect Pointer

This block is the data-memory front end of a small 8-bit core. It turns a 5-bit register address into a 7-bit physical address and serves the access. Address 00h is not a real register. An access to it goes through a 7-bit pointer register instead: the pointer's low five bits give the location and its top two bits give the bank. The same bank bits also steer direct accesses.

The lower half of the address space (00h–0Fh) is common to all banks and always lands in bank 0. Of that half, 01h–07h (apart from the pointer at 04h) are passed out to special-register hooks, and 08h–0Fh are general-purpose RAM. The upper half (10h–1Fh) is truly banked: each of the four banks has its own 16 bytes, at physical 10h, 30h, 50h and 70h.

Reads are combinational from the address, the enables and the pointer. Writes take effect at the rising clock edge. A separate port lets the core load the pointer directly.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous reset the pointer holds 00h, so a read of address 04h returns 80h (bank 0, location 0, bit 7 reading as 1).
- R2: Direct addresses 08h–0Fh reach the same byte whatever the bank bits are, and `phys_addr` equals the address with bits 6:5 zero.
- R3: Direct addresses 10h–1Fh reach one of four separate 16-byte areas, chosen by pointer bits 6:5. `phys_addr` is {pointer[6:5], address}.
- R4: Address 00h takes its location from pointer bits 4:0 and then follows the same folding and banking as R2 and R3.
- R5: An access to address 00h while pointer bits 4:0 are 00h returns 00h. It writes nothing, raises no special-register strobe and gives `phys_addr` 00h.
- R6: A read of location 04h (direct, or indirect through the pointer) returns {1, pointer[6:0]}. A write to it stores `wr_data[6:0]` into the pointer.
- R7: Locations 01h, 02h, 03h, 05h, 06h and 07h go to the hooks. `spec_addr` is the physical address bits 2:0, `spec_rd` follows `rd_en`, `spec_wr` follows `wr_en`, `spec_wdata` is `wr_data`, and the read returns `spec_rdata`.
- R8: `ptr_we` loads `ptr_wdata` into the pointer at the next edge. If a bus write to the pointer happens in the same cycle, `ptr_we` wins.
- R9: With `rd_en` low, `rd_data` is 00h. A write lands at the rising edge and a read in the next cycle returns it.
- R10: `phys_addr` always shows the effective 7-bit address of the present `addr` and pointer, whether or not an enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register address, 00h means indirect |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| ptr_we | input | 1 | Direct pointer load enable |
| ptr_wdata | input | 7 | Direct pointer load value |
| phys_addr | output | 7 | Effective physical address |
| spec_addr | output | 3 | Special-register index |
| spec_rd | output | 1 | Special-register read strobe |
| spec_wr | output | 1 | Special-register write strobe |
| spec_wdata | output | 8 | Special-register write data |
| spec_rdata | input | 8 | Special-register read data |

## Verification
A wrong pointer value shows up at once on `phys_addr` for any access to 00h or to 10h–1Fh, and in the very next read of location 04h. A wrong RAM index or a failure to fold the lower half shows up only when a byte written under one bank is read back under another. For that reason the bench fills every bank and then reads all 32 addresses under all 128 pointer values. A null access that leaks a write shows up as a corrupted byte or a stray strobe in the same cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int DATA_W      = 8;
    localparam int LOC_W       = 5;
    localparam int BANK_W      = 2;
    localparam int PTR_W       = LOC_W + BANK_W;
    localparam int HALF        = 1 << (LOC_W - 1);
    localparam int NBANK       = 1 << BANK_W;
    localparam int SPECIAL_CNT = 8;
    localparam int SPEC_AW     = $clog2(SPECIAL_CNT);
    localparam int LOW_GP      = HALF - SPECIAL_CNT;
    localparam int RAM_DEPTH   = LOW_GP + NBANK * HALF;
    localparam int RAM_AW      = $clog2(RAM_DEPTH);
    localparam int PTR_LOC     = 4;

    typedef logic [LOC_W-1:0]  loc_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [RAM_AW-1:0] ridx_t;

    typedef enum logic [1:0] {
        TGT_NULL,
        TGT_PTR,
        TGT_SPEC,
        TGT_RAM
    } target_e;

    typedef struct packed {
        target_e tgt;
        ptr_t    phys;
        ridx_t   ram_idx;
    } resolve_t;

    function automatic resolve_t resolve(input loc_t a, input ptr_t p);
        resolve_t r;
        loc_t     loc;
        loc = (a == '0) ? p[LOC_W-1:0] : a;
        if (loc[LOC_W-1]) begin
            r.phys    = {p[PTR_W-1:LOC_W], loc};
            r.ram_idx = ridx_t'(LOW_GP) + ridx_t'({p[PTR_W-1:LOC_W], loc[LOC_W-2:0]});
        end else begin
            r.phys    = ptr_t'(loc);
            r.ram_idx = ridx_t'(loc) - ridx_t'(SPECIAL_CNT);
        end
        if (loc == '0)
            r.tgt = TGT_NULL;
        else if (loc == loc_t'(PTR_LOC))
            r.tgt = TGT_PTR;
        else if (int'(loc) < SPECIAL_CNT)
            r.tgt = TGT_SPEC;
        else
            r.tgt = TGT_RAM;
        return r;
    endfunction
endpackage

// File: rtl/brf_ptr.sv
module brf_ptr
    import brf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_we,
    input  ptr_t bus_wd,
    input  logic port_we,
    input  ptr_t port_wd,
    output ptr_t ptr_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (port_we)
            ptr_q <= port_wd;
        else if (bus_we)
            ptr_q <= bus_wd;
    end

    // R8
    port_load_chk: assert property (@(posedge clk) disable iff (rst)
        port_we |=> ptr_q == $past(port_wd));

    // R6
    bus_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !port_we) |=> ptr_q == $past(bus_wd));

    // R1
    reset_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ptr_q == '0);
endmodule

// File: rtl/brf_ram.sv
module brf_ram
    import brf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t widx,
    input  data_t wd,
    input  ridx_t ridx,
    output data_t rd
);
    data_t mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[widx] <= wd;
    end

    assign rd = mem[ridx];

    // R9
    write_read_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && ridx == $past(widx)) |-> rd == $past(wd));

    // R2
    index_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> int'(widx) < RAM_DEPTH);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LOC_W-1:0]   addr,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ptr_we,
    input  logic [PTR_W-1:0]   ptr_wdata,
    output logic [PTR_W-1:0]   phys_addr,
    output logic [SPEC_AW-1:0] spec_addr,
    output logic               spec_rd,
    output logic               spec_wr,
    output logic [DATA_W-1:0]  spec_wdata,
    input  logic [DATA_W-1:0]  spec_rdata
);
    ptr_t     ptr_q;
    resolve_t res;
    data_t    ram_rd;
    logic     ram_we;
    logic     ptr_bus_we;

    assign res        = resolve(addr, ptr_q);
    assign phys_addr  = res.phys;
    assign ram_we     = wr_en && (res.tgt == TGT_RAM);
    assign ptr_bus_we = wr_en && (res.tgt == TGT_PTR);
    assign spec_rd    = rd_en && (res.tgt == TGT_SPEC);
    assign spec_wr    = wr_en && (res.tgt == TGT_SPEC);
    assign spec_addr  = res.phys[SPEC_AW-1:0];
    assign spec_wdata = wr_data;

    brf_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .bus_we  (ptr_bus_we),
        .bus_wd  (wr_data[PTR_W-1:0]),
        .port_we (ptr_we),
        .port_wd (ptr_wdata),
        .ptr_q   (ptr_q)
    );

    brf_ram u_ram (
        .clk  (clk),
        .rst  (rst),
        .we   (ram_we),
        .widx (res.ram_idx),
        .wd   (wr_data),
        .ridx (res.ram_idx),
        .rd   (ram_rd)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (res.tgt)
                TGT_PTR:  rd_data = data_t'({1'b1, ptr_q});
                TGT_SPEC: rd_data = spec_rdata;
                TGT_RAM:  rd_data = ram_rd;
                default:  rd_data = '0;
            endcase
        end
    end

    // R5
    null_access_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == '0 && ptr_q[LOC_W-1:0] == '0) |->
            (!spec_rd && !spec_wr && !ram_we && !ptr_bus_we && rd_data == '0 && phys_addr == '0));

    // R10
    direct_loc_chk: assert property (@(posedge clk) disable iff (rst)
        addr != '0 |-> phys_addr[LOC_W-1:0] == addr);

    // R2
    fold_low_chk: assert property (@(posedge clk) disable iff (rst)
        !phys_addr[LOC_W-1] |-> phys_addr[PTR_W-1:LOC_W] == '0);

    // R3
    bank_high_chk: assert property (@(posedge clk) disable iff (rst)
        phys_addr[LOC_W-1] |-> phys_addr[PTR_W-1:LOC_W] == ptr_q[PTR_W-1:LOC_W]);

    // R7
    one_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, spec_wr, ptr_bus_we}));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);
endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ptr_we = 1'b0;
    logic [6:0] ptr_wdata = '0;
    logic [6:0] phys_addr;
    logic [2:0] spec_addr;
    logic       spec_rd;
    logic       spec_wr;
    logic [7:0] spec_wdata;
    logic [7:0] spec_rdata;

    int checks = 0;
    int errors = 0;
    logic [6:0] m_ptr;
    logic [7:0] m_mem [128];
    bit         m_ok  [128];

    always #2.5 clk = ~clk;

    assign spec_rdata = 8'hB0 | {5'b0, spec_addr};

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .phys_addr(phys_addr), .spec_addr(spec_addr), .spec_rd(spec_rd),
        .spec_wr(spec_wr), .spec_wdata(spec_wdata), .spec_rdata(spec_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] m_loc(input logic [4:0] a);
        return (a == 5'd0) ? m_ptr[4:0] : a;
    endfunction

    function automatic logic [6:0] m_phys(input logic [4:0] a);
        logic [4:0] l;
        l = m_loc(a);
        return l[4] ? {m_ptr[6:5], l} : {2'b00, l};
    endfunction

    // one access: check combinational results, then let the edge commit it
    task automatic acc(input logic [4:0] a, input bit rd, input bit wr, input logic [7:0] wd);
        logic [4:0] l;
        logic [6:0] p;
        bit         spc;
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wr_data = wd;
        #1;
        l = m_loc(a);
        p = m_phys(a);
        spc = (l != 0) && (l != 4) && (l < 8);
        chk(l[4] ? "R3 phys" : (a == 0 ? "R4 phys" : "R2 phys"), phys_addr, (l == 0) ? 0 : p);
        chk("R7 spec_rd", spec_rd, rd && spc);
        chk("R7 spec_wr", spec_wr, wr && spc);
        if (spc && (rd || wr)) chk("R7 spec_addr", spec_addr, p[2:0]);
        if (spc && wr) chk("R7 spec_wdata", spec_wdata, wd);
        if (!rd)
            chk("R9 idle read", rd_data, 0);
        else if (l == 0)
            chk("R5 null read", rd_data, 0);
        else if (l == 4)
            chk("R6 ptr read", rd_data, {1'b1, m_ptr});
        else if (spc)
            chk("R7 spec read", rd_data, 8'hB0 | p[2:0]);
        else if (m_ok[p])
            chk(l[4] ? "R3 ram read" : "R2 ram read", rd_data, m_mem[p]);
        @(posedge clk);
        if (wr && l != 0) begin
            if (l == 4) m_ptr = wd[6:0];
            else if (!spc) begin m_mem[p] = wd; m_ok[p] = 1'b1; end
        end
    endtask

    task automatic set_ptr(input logic [6:0] v);
        @(negedge clk);
        rd_en = 0; wr_en = 0; ptr_we = 1; ptr_wdata = v;
        @(posedge clk);
        m_ptr = v;
        @(negedge clk);
        ptr_we = 0;
    endtask

    task automatic read_sweep();
        for (int f = 0; f < 128; f++) begin
            set_ptr(7'(f));
            for (int a = 0; a < 32; a++) acc(5'(a), 1, 0, 8'h00);
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) m_ok[i] = 1'b0;
        m_ptr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        acc(5'd4, 1, 0, 8'h00);
        chk("R1 reset ptr", rd_data, 8'h80);
        // R5 null access with zero pointer: read and write
        acc(5'd0, 1, 1, 8'h5C);
        acc(5'd4, 1, 0, 8'h00);
        chk("R5 null write no effect", rd_data, 8'h80);
        // fill every RAM byte directly under each bank
        for (int b = 0; b < 4; b++) begin
            set_ptr({2'(b), 5'd0});
            for (int a = 8; a < 32; a++) acc(5'(a), 0, 1, 8'((a * 7 + b * 53 + 1) & 8'hFF));
        end
        // R2 R3 R4 full readback under all pointer values
        read_sweep();
        // R4 R6 R7 indirect writes through every pointer value
        for (int f = 0; f < 128; f++) begin
            set_ptr(7'(f));
            acc(5'd0, 1, 1, 8'(f) ^ 8'hA5);
        end
        read_sweep();
        // R8 pointer port beats a same-cycle bus write to the pointer
        @(negedge clk);
        addr = 5'd4; rd_en = 0; wr_en = 1; wr_data = 8'h6A; ptr_we = 1; ptr_wdata = 7'h15;
        @(posedge clk);
        m_ptr = 7'h15;
        @(negedge clk);
        ptr_we = 0; wr_en = 0;
        acc(5'd4, 1, 0, 8'h00);
        chk("R8 port priority", rd_data, 8'h95);
        // R10 phys_addr with no enable active
        acc(5'd0, 0, 0, 8'h00);
        acc(5'd19, 0, 0, 8'h00);
        // R9 write then read next cycle
        acc(5'd31, 0, 1, 8'h3C);
        acc(5'd31, 1, 0, 8'h00);
        chk("R9 write visible", rd_data, 8'h3C);
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule